// File: doc/BRIEF.md
# Adjustable PTP System Timer

This block keeps a free-running precision time count in units of 1/256 ns. On every clock it adds a rate value with 18 integer bits and 32 fractional bits, so the count carries a 2^-40 ns resolution internally and drifts by no more than the rate's rounding. Software-side logic steers the count with typed commands on a toggle-triggered adjustment port. A command can step the time by a signed amount, load a new integer rate, or trim the rate by a signed fraction. Both edges of the adjustment toggle launch a command.

An external reference time comes with a sync toggle. When the overwrite enable is high and the sync toggle changes, the block compares its own time with the reference. If the absolute gap exceeds the `THRESH` parameter, the time is loaded with the reference exactly. The sync level, registered once, is exported. The top bit of the exported time is replaced by that level, so a reader can tell which sync edge came last.

Top module: `ptp_timer`

## Requirements
- R1: During and just after reset the time is 0, the sync output is 0, and the rate holds the nominal value 1705908783169 in 2^-40 ns units (about 1.551515 ns).
- R2: With no command and no load, each clock adds the 50-bit rate (upper 18 bits in 1/256 ns, lower 32 bits fractional) to the time and its 32-bit hidden fraction, with carry from the fraction into the time.
- R3: Kind 2'b00 adds bits [17:0] of the adjustment word, sign-extended, to the time at the clock edge that sees the toggle change, on top of that cycle's rate. Bits [31:18] are ignored and the sum wraps modulo 2^55.
- R4: Kind 2'b01 loads the rate with word bits [17:0] as its integer part and clears its fractional part. The new rate is first added on the following clock.
- R5: Kind 2'b10 adds the full 32-bit word, sign-extended, to the rate in 2^-40 ns units.
- R6: Kind 2'b11 changes neither the time nor the rate.
- R7: A command fires on a rising or a falling change of the adjustment toggle. A steady toggle fires nothing, whatever the word and kind are.
- R8: When a sync toggle change is seen with overwrite enabled and |time - reference| > THRESH, the time becomes the reference exactly and the hidden fraction is cleared.
- R9: No load happens when the gap is at most THRESH, when overwrite is low, or when the sync toggle is steady.
- R10: The sync output equals the sync input as sampled one clock earlier. Exported time bit 54 equals that sync output, and bits [53:0] are the time.
- R11: A load has priority over a step that falls on the same edge. A rate command on that edge still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_time_i | input | 55 | Reference time, 1/256 ns units |
| ref_sync_i | input | 1 | Sync toggle marking the reference as valid |
| ovr_en_i | input | 1 | Allows a load at the next sync change |
| adj_word_i | input | 32 | Adjustment value |
| adj_kind_i | input | 2 | Adjustment kind (step, set rate, trim rate, none) |
| adj_tog_i | input | 1 | Adjustment toggle; each change fires one command |
| time_o | output | 55 | Time, bit 54 replaced by the last sync level |
| sync_o | output | 1 | Registered sync level |

## Verification
The assertions assume that both toggles are low during reset. A level already high at the first edge would be taken as a change. They also assume that the reference time is held steady on the edge where the sync toggle changes. The stimulus drives every input between edges, starts both toggles at zero, and holds the reference whenever the sync toggle moves. It spaces sync changes at least a dozen cycles apart. Offsets around the threshold, from THRESH+2 below to THRESH+2 above, are swept with overwrite both on and off.

// File: rtl/ptp_timer_pkg.sv
package ptp_timer_pkg;
  localparam int TIME_W     = 55;
  localparam int FRAC_W     = 32;
  localparam int RATE_INT_W = 18;
  localparam int ADJ_W      = 32;
  localparam int ACC_W      = TIME_W + FRAC_W;
  localparam int RATE_W     = RATE_INT_W + FRAC_W;

  typedef enum logic [1:0] {
    ADJ_STEP      = 2'b00,
    ADJ_SET_RATE  = 2'b01,
    ADJ_TRIM_RATE = 2'b10,
    ADJ_NONE      = 2'b11
  } adj_kind_e;

  // signed step taken from the low word bits, placed above the fraction
  function automatic logic [ACC_W-1:0] step_to_acc(input logic [ADJ_W-1:0] w);
    logic [TIME_W-1:0] s;
    s = {{(TIME_W-RATE_INT_W){w[RATE_INT_W-1]}}, w[RATE_INT_W-1:0]};
    return {s, {FRAC_W{1'b0}}};
  endfunction

  function automatic logic [RATE_W-1:0] set_rate(input logic [ADJ_W-1:0] w);
    return {w[RATE_INT_W-1:0], {FRAC_W{1'b0}}};
  endfunction

  function automatic logic [RATE_W-1:0] trim_rate(input logic [RATE_W-1:0] r,
                                                  input logic [ADJ_W-1:0] w);
    return r + {{(RATE_W-ADJ_W){w[ADJ_W-1]}}, w};
  endfunction

  function automatic logic [TIME_W:0] time_gap(input logic [TIME_W-1:0] a,
                                               input logic [TIME_W-1:0] b);
    return (a >= b) ? {1'b0, a - b} : {1'b0, b - a};
  endfunction
endpackage

// File: rtl/ptp_toggle_det.sv
module ptp_toggle_det (
  input  logic clk,
  input  logic rst_n,
  input  logic tog_i,
  output logic level_q,
  output logic fire
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= tog_i;
  end

  assign fire = tog_i ^ level_q;
endmodule

// File: rtl/ptp_rate_reg.sv
module ptp_rate_reg
  import ptp_timer_pkg::*;
#(
  parameter logic [RATE_W-1:0] RESET_RATE = 50'd1705908783169
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [1:0]        kind,
  input  logic [ADJ_W-1:0]  word,
  output logic [RATE_W-1:0] rate_q
);
  logic [RATE_W-1:0] rate_d;

  always_comb begin
    rate_d = rate_q;
    if (fire) begin
      unique case (adj_kind_e'(kind))
        ADJ_SET_RATE:  rate_d = set_rate(word);
        ADJ_TRIM_RATE: rate_d = trim_rate(rate_q, word);
        default:       rate_d = rate_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rate_q <= RESET_RATE;
    else        rate_q <= rate_d;
  end

  a_r4_frac_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && kind == 2'b01) |=> rate_q[FRAC_W-1:0] == '0);
  a_r6_none_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && kind == 2'b11) |=> $stable(rate_q));
  a_r7_quiet_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(rate_q));
endmodule

// File: rtl/ptp_time_acc.sv
module ptp_time_acc
  import ptp_timer_pkg::*;
#(
  parameter logic [TIME_W-1:0] THRESH = 55'd1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              step_fire,
  input  logic [ADJ_W-1:0]  word_i,
  input  logic              sync_fire,
  input  logic              ovr_i,
  input  logic [TIME_W-1:0] ref_i,
  output logic [TIME_W-1:0] time_q,
  output logic              load_fire
);
  logic [ACC_W-1:0] acc_q, acc_d, step_amt;
  logic [TIME_W:0]  gap;

  assign time_q    = acc_q[ACC_W-1:FRAC_W];
  assign gap       = time_gap(time_q, ref_i);
  assign load_fire = sync_fire && ovr_i && (gap > {1'b0, THRESH});
  assign step_amt  = step_fire ? step_to_acc(word_i) : '0;

  always_comb begin
    if (load_fire) acc_d = {ref_i, {FRAC_W{1'b0}}};
    else           acc_d = acc_q + {{(ACC_W-RATE_W){1'b0}}, rate_i} + step_amt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  a_r8_load_exact: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> (time_q == $past(ref_i)) && (acc_q[FRAC_W-1:0] == '0));
  a_r9_no_load_without_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_fire |-> !load_fire);
endmodule

// File: rtl/ptp_timer.sv
module ptp_timer
  import ptp_timer_pkg::*;
#(
  parameter logic [TIME_W-1:0] THRESH     = 55'd1024,
  parameter logic [RATE_W-1:0] RESET_RATE = 50'd1705908783169,
  parameter bit                EDGE_FLAG  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] ref_time_i,
  input  logic              ref_sync_i,
  input  logic              ovr_en_i,
  input  logic [ADJ_W-1:0]  adj_word_i,
  input  logic [1:0]        adj_kind_i,
  input  logic              adj_tog_i,
  output logic [TIME_W-1:0] time_o,
  output logic              sync_o
);
  logic              adj_fire, adj_lvl;
  logic              sync_fire, sync_lvl;
  logic              step_fire, load_fire;
  logic [RATE_W-1:0] rate_q;
  logic [TIME_W-1:0] time_q;

  ptp_toggle_det u_adj_det (
    .clk(clk), .rst_n(rst_n), .tog_i(adj_tog_i), .level_q(adj_lvl), .fire(adj_fire)
  );
  ptp_toggle_det u_sync_det (
    .clk(clk), .rst_n(rst_n), .tog_i(ref_sync_i), .level_q(sync_lvl), .fire(sync_fire)
  );

  assign step_fire = adj_fire && (adj_kind_i == ADJ_STEP);

  ptp_rate_reg #(.RESET_RATE(RESET_RATE)) u_rate (
    .clk(clk), .rst_n(rst_n), .fire(adj_fire), .kind(adj_kind_i),
    .word(adj_word_i), .rate_q(rate_q)
  );

  ptp_time_acc #(.THRESH(THRESH)) u_acc (
    .clk(clk), .rst_n(rst_n), .rate_i(rate_q), .step_fire(step_fire),
    .word_i(adj_word_i), .sync_fire(sync_fire), .ovr_i(ovr_en_i),
    .ref_i(ref_time_i), .time_q(time_q), .load_fire(load_fire)
  );

  assign sync_o = sync_lvl;

  generate
    if (EDGE_FLAG) begin : g_flag
      assign time_o = {sync_lvl, time_q[TIME_W-2:0]};
    end else begin : g_plain
      assign time_o = time_q;
    end
  endgenerate

  a_r10_sync_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> sync_o == $past(ref_sync_i));
  a_r11_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (load_fire && step_fire) |=> time_q == $past(ref_time_i));
endmodule

// File: tb/test_ptp_timer.sv
module test_ptp_timer;
  localparam logic [54:0] TH  = 55'd8;
  localparam logic [49:0] INC = 50'd1705908783169;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [54:0] ref_time = '0;
  logic        ref_sync = 1'b0, ovr_en = 1'b0, adj_tog = 1'b0;
  logic [31:0] adj_word = '0;
  logic [1:0]  adj_kind = '0;
  logic [54:0] time_o;
  logic        sync_o;

  int n_chk = 0, n_bad = 0;
  logic [54:0] mt;
  logic [31:0] mf;
  logic [49:0] mr;
  logic        p_adj, p_sync;

  always #2.5 clk = ~clk;

  ptp_timer #(.THRESH(TH), .RESET_RATE(INC)) i_ptp_timer (
    .clk(clk), .rst_n(rst_n), .ref_time_i(ref_time), .ref_sync_i(ref_sync),
    .ovr_en_i(ovr_en), .adj_word_i(adj_word), .adj_kind_i(adj_kind),
    .adj_tog_i(adj_tog), .time_o(time_o), .sync_o(sync_o)
  );

  task automatic check(input string req, input logic [54:0] act, input logic [54:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock: model the edge arithmetically, then compare after it
  task automatic tick(input string req);
    logic af, sf, ow, c;
    logic [54:0] d, st;
    af = (adj_tog != p_adj);
    sf = (ref_sync != p_sync);
    d  = (mt >= ref_time) ? mt - ref_time : ref_time - mt;
    ow = sf && ovr_en && (d > TH);
    st = (af && adj_kind == 2'b00) ? {{37{adj_word[17]}}, adj_word[17:0]} : 55'd0;
    if (ow) begin
      mt = ref_time; mf = '0;
    end else begin
      {c, mf} = {1'b0, mf} + {1'b0, mr[31:0]};
      mt = mt + {37'd0, mr[49:32]} + {54'd0, c} + st;
    end
    if (af && adj_kind == 2'b01) mr = {adj_word[17:0], 32'd0};
    if (af && adj_kind == 2'b10) mr = mr + {{18{adj_word[31]}}, adj_word};
    p_adj = adj_tog; p_sync = ref_sync;
    @(posedge clk); #1;
    check(req, time_o, {ref_sync, mt[53:0]});
    check("R10", {54'd0, sync_o}, {54'd0, ref_sync});
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) tick(req);
  endtask

  task automatic cmd(input logic [1:0] k, input logic [31:0] w, input string req);
    adj_kind = k; adj_word = w; adj_tog = ~adj_tog;
    tick(req);
    adj_word = 32'hDEAD_BEEF; adj_kind = 2'b00;
    idle(3, req);
  endtask

  task automatic sync_at(input logic signed [55:0] off, input logic ov, input string req);
    ref_time = mt + off[54:0];
    ovr_en = ov; ref_sync = ~ref_sync;
    tick(req);
    idle(11, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    mt = '0; mf = '0; mr = INC; p_adj = 1'b0; p_sync = 1'b0;
    repeat (3) @(posedge clk); #1;
    check("R1", time_o, 55'd0);
    check("R1", {54'd0, sync_o}, 55'd0);
    @(negedge clk); rst_n = 1'b1;
    idle(300, "R1 R2");
    // R3 steps, both toggle edges (R7), upper bits ignored
    cmd(2'b00, 32'h0000_0100, "R3");
    cmd(2'b00, 32'h0003_FFFF, "R3");
    cmd(2'b00, 32'hFFFC_0005, "R3");
    cmd(2'b00, 32'h0002_0000, "R3");
    cmd(2'b00, 32'h0001_FFFF, "R7");
    // R3 wrap: load near the top and step past it
    sync_at(-56'sd100, 1'b1, "R8");
    ref_time = 55'h7F_FFFF_FFFF_FFF0; ref_sync = ~ref_sync; tick("R8"); idle(11, "R8");
    cmd(2'b00, 32'h0000_0400, "R3");
    // R4 rate loads
    for (int k = 0; k < 5; k++) begin
      logic [31:0] w [5] = '{32'h0000_0000, 32'h0000_0001, 32'h0003_FFFF,
                             32'hFFFC_0190, 32'h0000_018D};
      cmd(2'b01, w[k], "R4");
      idle(20, "R4");
    end
    // R5 trims
    for (int k = 0; k < 4; k++) begin
      logic [31:0] w [4] = '{32'h8000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h0123_4567};
      cmd(2'b10, w[k], "R5");
      idle(20, "R5");
    end
    // R6 unused kind
    for (int k = 0; k < 4; k++) cmd(2'b11, 32'h1357_9BDF << k, "R6");
    // R7 steady toggle with changing word and kind
    for (int k = 0; k < 16; k++) begin
      adj_kind = k[1:0]; adj_word = 32'h0001_0101 * k;
      tick("R7");
    end
    // R8/R9 threshold sweep, overwrite on and off
    for (int o = -10; o <= 10; o++) sync_at(56'(signed'(o)), 1'b1, "R8 R9");
    for (int o = -10; o <= 10; o += 5) sync_at(56'(signed'(o)), 1'b0, "R9");
    ovr_en = 1'b1; ref_time = mt + 55'd500;
    idle(12, "R9");
    // R11 load and step on the same edge, rate set too
    ref_time = mt + 55'd999; ref_sync = ~ref_sync;
    adj_kind = 2'b00; adj_word = 32'h0000_7777; adj_tog = ~adj_tog;
    tick("R11");
    idle(11, "R11");
    ref_time = mt + 55'd777; ref_sync = ~ref_sync;
    adj_kind = 2'b01; adj_word = 32'h0000_0200; adj_tog = ~adj_tog;
    tick("R11");
    idle(20, "R11");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule